// File: doc/BRIEF.md
# Clock Control Register with Fast Wake-up Sequencer

This block holds the 8-bit control word of a clock generator and runs the small state machine for a quick return from full stop. Software reads the control word at any time and writes it through a simple register port. A write only changes the fields whose lock condition is false in that cycle. The lock conditions come from live system state: self-clock mode, PLL chosen as the system clock, and PLL-wait. PLL-wait also holds the automatic-bandwidth field at 1.

The block turns the stored fields and the stop/wake status into enables for the PLL, the oscillator and the clock monitor, a filter bandwidth select, and a system-clock source select. Fast wake-up is armed when both the fast-wake field and the self-clock enable field are set. A wake from full stop then resumes in self-clock mode with the oscillator and monitor off. Software ends that state by clearing the fast-wake field. This starts a clock-quality handshake. If the check passes, the clock source moves back to the oscillator and an interrupt flag is raised. Software clears the flag by writing 1 to it at the second address.

Top module: `clkctl_wake`

## Requirements
- R1: After reset the control word reads 0xF1 (bit7 monitor enable, bit6 PLL on, bit5 auto bandwidth, bit4 acquisition, bit3 fast wake, bit2, bit1, bit0 self-clock enable) and the flag is 0. The oscillator, the monitor and the PLL are enabled, `clk_src_osc_o` is 1 and `qc_start_o` is 0.
- R2: When `rd_en` is 1, `rdata` returns the control word at `addr`=0 or the flag in bit0 at `addr`=1. When `rd_en` is 0, `rdata` is 0.
- R3: While self-clock mode is active, a write leaves bit7 unchanged. Self-clock mode is active when `scm_i` is 1 or when the sequencer is in a fast-wake, check or hold state. The unlocked bits of the same write still take effect.
- R4: While `pll_sel_i` is 1, a write leaves bit6 unchanged and the other unlocked bits are written.
- R5: While `pll_wait_i` is 1, a write cannot clear bit5, and bit5 reads 1 one cycle after `pll_wait_i` is seen.
- R6: `bw_high_o` follows `vco_far_i` when bit5 is 1. Otherwise it equals bit4.
- R7: `pll_en_o` is 1 when bit6 is 1 or self-clock mode is active, and bit6 still reads its stored value.
- R8: `cm_en_o` equals bit7, except that it is 0 in stop with `stop_pin_i`=0 and in the fast-wake state.
- R9: A `wake_i` pulse in full stop, with bit3=1 and bit0=1, enters the fast-wake state on the next cycle. In that state `clk_src_osc_o`=0, `osc_en_o`=0 and `cm_en_o`=0, and the flag stays 0. With bit0=0 the same wake returns to normal run with `clk_src_osc_o`=1.
- R10: A write that clears bit3 in the fast-wake state turns on `osc_en_o` and `cm_en_o` (per bit7) in the next cycle. It also pulses `qc_start_o` for exactly one cycle.
- R11: When the check reports `qc_done_i`=1 with `qc_pass_i`=1, the next cycle has `clk_src_osc_o`=1 and flag=1.
- R12: When the check reports a failure, the block stays in self-clock mode (`clk_src_osc_o`=0) with flag=0. Writing 1 to bit0 at `addr`=1 clears the flag.
- R13: In stop with `stop_pin_i`=0 `osc_en_o` is 0. In stop with `stop_pin_i`=1 the oscillator and monitor keep their run values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read enable |
| wr_en | input | 1 | Write enable |
| addr | input | 1 | 0 control word, 1 flag |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| scm_i | input | 1 | Self-clock mode forced by the clock monitor |
| pll_sel_i | input | 1 | PLL is the system clock source |
| pll_wait_i | input | 1 | PLL-wait setting |
| stop_pin_i | input | 1 | Stop-pin state (0 means full stop) |
| stop_req_i | input | 1 | Stop entry pulse |
| wake_i | input | 1 | Wake pulse |
| vco_far_i | input | 1 | VCO far from target (automatic bandwidth) |
| qc_done_i | input | 1 | Quality check finished |
| qc_pass_i | input | 1 | Quality check result |
| qc_start_o | output | 1 | Quality check start pulse |
| pll_en_o | output | 1 | PLL enable |
| osc_en_o | output | 1 | Oscillator enable |
| cm_en_o | output | 1 | Clock monitor enable |
| bw_high_o | output | 1 | High-bandwidth filter select |
| clk_src_osc_o | output | 1 | 1 oscillator clock, 0 self clock |
| scm_flag_o | output | 1 | Self-clock-mode interrupt flag |

## Verification
The bench builds the block with its default reset word of 0xF1. Any lock that is missing or has moved therefore shows up as a readback that differs from the table, starting from reset. With these defaults the monitor and fast-wake fields can be combined with stop, wake and check results. This covers the fast-wake entry, both outcomes of the quality check and the plain-wake path.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int unsigned CTL_W  = 8;
  localparam int unsigned B_MON  = 7;
  localparam int unsigned B_PLL  = 6;
  localparam int unsigned B_AUTO = 5;
  localparam int unsigned B_ACQ  = 4;
  localparam int unsigned B_FW   = 3;
  localparam int unsigned B_SCME = 0;

  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_STOP    = 3'd1,
    ST_FASTSCM = 3'd2,
    ST_CHECK   = 3'd3,
    ST_HOLD    = 3'd4
  } wake_st_e;
endpackage

// File: rtl/clkctl_regs.sv
module clkctl_regs
  import clkctl_pkg::*;
#(
  parameter logic [CTL_W-1:0] RST_VAL = 8'hF1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctl,
  input  logic [CTL_W-1:0] wdata,
  input  logic             lock_mon,
  input  logic             lock_pll,
  input  logic             lock_auto,
  input  logic             force_auto,
  output logic [CTL_W-1:0] ctl_q,
  output logic             fw_clear
);
  logic [CTL_W-1:0] lock_vec;
  logic [CTL_W-1:0] ctl_d;

  always_comb begin
    lock_vec         = '0;
    lock_vec[B_MON]  = lock_mon;
    lock_vec[B_PLL]  = lock_pll;
    lock_vec[B_AUTO] = lock_auto;
  end

  for (genvar i = 0; i < CTL_W; i++) begin : g_bit
    always_comb begin
      if (i == B_AUTO && force_auto) ctl_d[i] = 1'b1;
      else if (wr_ctl && !lock_vec[i]) ctl_d[i] = wdata[i];
      else ctl_d[i] = ctl_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= RST_VAL;
    else        ctl_q <= ctl_d;
  end

  assign fw_clear = wr_ctl && ctl_q[B_FW] && !wdata[B_FW];
endmodule

// File: rtl/clkctl_wake_seq.sv
module clkctl_wake_seq
  import clkctl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     stop_req_i,
  input  logic     wake_i,
  input  logic     stop_pin_i,
  input  logic     fw_armed,
  input  logic     fw_clear,
  input  logic     qc_done_i,
  input  logic     qc_pass_i,
  input  logic     flag_clr,
  output wake_st_e st_q,
  output logic     qc_start_o,
  output logic     flag_o
);
  wake_st_e st_d;
  logic     start_d;
  logic     flag_d;

  always_comb begin
    st_d    = st_q;
    start_d = 1'b0;
    unique case (st_q)
      ST_RUN:  if (stop_req_i) st_d = ST_STOP;
      ST_STOP: begin
        if (wake_i) begin
          if (fw_armed && !stop_pin_i) st_d = ST_FASTSCM;
          else                         st_d = ST_RUN;
        end
      end
      ST_FASTSCM: begin
        if (fw_clear) begin
          st_d    = ST_CHECK;
          start_d = 1'b1;
        end
      end
      ST_CHECK: begin
        if (qc_done_i) st_d = qc_pass_i ? ST_RUN : ST_HOLD;
      end
      ST_HOLD: if (stop_req_i) st_d = ST_STOP;
      default: st_d = ST_RUN;
    endcase
  end

  always_comb begin
    flag_d = flag_o;
    if (flag_clr) flag_d = 1'b0;
    if (st_q == ST_CHECK && qc_done_i && qc_pass_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_RUN;
      qc_start_o <= 1'b0;
      flag_o     <= 1'b0;
    end else begin
      st_q       <= st_d;
      qc_start_o <= start_d;
      flag_o     <= flag_d;
    end
  end
endmodule

// File: rtl/clkctl_wake.sv
module clkctl_wake
  import clkctl_pkg::*;
#(
  parameter logic [CTL_W-1:0] RST_VAL = 8'hF1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic             addr,
  input  logic [CTL_W-1:0] wdata,
  output logic [CTL_W-1:0] rdata,
  input  logic             scm_i,
  input  logic             pll_sel_i,
  input  logic             pll_wait_i,
  input  logic             stop_pin_i,
  input  logic             stop_req_i,
  input  logic             wake_i,
  input  logic             vco_far_i,
  input  logic             qc_done_i,
  input  logic             qc_pass_i,
  output logic             qc_start_o,
  output logic             pll_en_o,
  output logic             osc_en_o,
  output logic             cm_en_o,
  output logic             bw_high_o,
  output logic             clk_src_osc_o,
  output logic             scm_flag_o
);
  logic [CTL_W-1:0] ctl_q;
  logic             fw_clear;
  logic             wr_ctl;
  logic             flag_clr;
  logic             scm_act;
  logic             full_stop;
  wake_st_e         st_q;

  assign wr_ctl   = wr_en && !addr;
  assign flag_clr = wr_en && addr && wdata[0];

  assign scm_act   = scm_i || (st_q == ST_FASTSCM) || (st_q == ST_CHECK) || (st_q == ST_HOLD);
  assign full_stop = (st_q == ST_STOP) && !stop_pin_i;

  clkctl_regs #(.RST_VAL(RST_VAL)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ctl     (wr_ctl),
    .wdata      (wdata),
    .lock_mon   (scm_act),
    .lock_pll   (pll_sel_i),
    .lock_auto  (pll_wait_i),
    .force_auto (pll_wait_i),
    .ctl_q      (ctl_q),
    .fw_clear   (fw_clear)
  );

  clkctl_wake_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_req_i (stop_req_i),
    .wake_i     (wake_i),
    .stop_pin_i (stop_pin_i),
    .fw_armed   (ctl_q[B_FW] && ctl_q[B_SCME]),
    .fw_clear   (fw_clear),
    .qc_done_i  (qc_done_i),
    .qc_pass_i  (qc_pass_i),
    .flag_clr   (flag_clr),
    .st_q       (st_q),
    .qc_start_o (qc_start_o),
    .flag_o     (scm_flag_o)
  );

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (addr) rdata[0] = scm_flag_o;
      else      rdata    = ctl_q;
    end
  end

  assign pll_en_o      = ctl_q[B_PLL] || scm_act;
  assign osc_en_o      = !(full_stop || st_q == ST_FASTSCM);
  assign cm_en_o       = ctl_q[B_MON] && !full_stop && (st_q != ST_FASTSCM);
  assign bw_high_o     = ctl_q[B_AUTO] ? vco_far_i : ctl_q[B_ACQ];
  assign clk_src_osc_o = !scm_act;
endmodule

// File: rtl/clkctl_wake_chk.sv
module clkctl_wake_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       addr,
  input logic       scm_i,
  input logic       pll_sel_i,
  input logic       pll_wait_i,
  input logic       qc_done_i,
  input logic       qc_pass_i,
  input logic       qc_start_o,
  input logic       pll_en_o,
  input logic       cm_en_o,
  input logic       clk_src_osc_o,
  input logic       scm_flag_o,
  input logic [7:0] ctl_q
);
  p_mon_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && (scm_i || !clk_src_osc_o)) |=> $stable(ctl_q[7]));

  p_pll_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && pll_sel_i) |=> $stable(ctl_q[6]));

  p_auto_force_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pll_wait_i |=> ctl_q[5]);

  p_pll_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[6] |-> pll_en_o);

  p_cm_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cm_en_o |-> ctl_q[7]);

  p_start_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    qc_start_o |=> !qc_start_o);

  p_flag_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scm_flag_o) |-> $past(qc_done_i && qc_pass_i));
endmodule

bind clkctl_wake clkctl_wake_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_en         (wr_en),
  .addr          (addr),
  .scm_i         (scm_i),
  .pll_sel_i     (pll_sel_i),
  .pll_wait_i    (pll_wait_i),
  .qc_done_i     (qc_done_i),
  .qc_pass_i     (qc_pass_i),
  .qc_start_o    (qc_start_o),
  .pll_en_o      (pll_en_o),
  .cm_en_o       (cm_en_o),
  .clk_src_osc_o (clk_src_osc_o),
  .scm_flag_o    (scm_flag_o),
  .ctl_q         (ctl_q)
);

// File: tb/clkctl_wake_bench.sv
module clkctl_wake_bench;
  localparam int CLK_P = 10;

  logic       clk, rst_n, rd_en, wr_en, addr;
  logic [7:0] wdata, rdata;
  logic scm_i, pll_sel_i, pll_wait_i, stop_pin_i, stop_req_i, wake_i, vco_far_i;
  logic qc_done_i, qc_pass_i;
  logic qc_start_o, pll_en_o, osc_en_o, cm_en_o, bw_high_o, clk_src_osc_o, scm_flag_o;

  int n_chk = 0;
  int n_bad = 0;

  clkctl_wake u_clkctl_wake (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .scm_i(scm_i), .pll_sel_i(pll_sel_i),
    .pll_wait_i(pll_wait_i), .stop_pin_i(stop_pin_i), .stop_req_i(stop_req_i),
    .wake_i(wake_i), .vco_far_i(vco_far_i), .qc_done_i(qc_done_i),
    .qc_pass_i(qc_pass_i), .qc_start_o(qc_start_o), .pll_en_o(pll_en_o),
    .osc_en_o(osc_en_o), .cm_en_o(cm_en_o), .bw_high_o(bw_high_o),
    .clk_src_osc_o(clk_src_osc_o), .scm_flag_o(scm_flag_o)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // vector: {scm, pll_sel, pll_wait, wdata, expected readback}
  typedef struct packed {
    logic       scm;
    logic       psel;
    logic       pwait;
    logic [7:0] wd;
    logic [7:0] exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b0, 1'b0, 8'h00, 8'h00},
    '{1'b1, 1'b0, 1'b0, 8'hFF, 8'h7F},
    '{1'b0, 1'b1, 1'b0, 8'h00, 8'h40},
    '{1'b0, 1'b0, 1'b1, 8'h00, 8'h20},
    '{1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5},
    '{1'b1, 1'b1, 1'b0, 8'h5A, 8'h9A},
    '{1'b1, 1'b1, 1'b1, 8'h00, 8'hA0},
    '{1'b0, 1'b0, 1'b0, 8'hF1, 8'hF1}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 1'b0; wdata = 8'h00;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    rd_en = 1'b0; addr = 1'b0;
  endtask

  task automatic pulse_stop(input logic pin);
    @(negedge clk);
    stop_pin_i = pin; stop_req_i = 1'b1;
    @(negedge clk);
    stop_req_i = 1'b0;
  endtask

  task automatic pulse_wake;
    @(negedge clk);
    wake_i = 1'b1;
    @(negedge clk);
    wake_i = 1'b0;
  endtask

  task automatic qc_report(input logic pass);
    @(negedge clk);
    qc_done_i = 1'b1; qc_pass_i = pass;
    @(negedge clk);
    qc_done_i = 1'b0; qc_pass_i = 1'b0;
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0; addr = 1'b0; wdata = 8'h00;
    scm_i = 1'b0; pll_sel_i = 1'b0; pll_wait_i = 1'b0; stop_pin_i = 1'b1;
    stop_req_i = 1'b0; wake_i = 1'b0; vco_far_i = 1'b0;
    qc_done_i = 1'b0; qc_pass_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(1'b0, r); chk("R1 ctl", r, 8'hF1);
    rd(1'b1, r); chk("R1 flag", r, 8'h00);
    chk("R1 outs", {3'b0, osc_en_o, cm_en_o, pll_en_o, clk_src_osc_o, qc_start_o}, 8'h1E);
    // R2 no read
    #1 chk("R2 idle rdata", rdata, 8'h00);

    // R3 R4 R5 table of locked writes
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      scm_i = VECS[i].scm; pll_sel_i = VECS[i].psel; pll_wait_i = VECS[i].pwait;
      wr(1'b0, VECS[i].wd);
      rd(1'b0, r); chk("R3/R4/R5 table", r, VECS[i].exp);
      scm_i = 1'b0; pll_sel_i = 1'b0; pll_wait_i = 1'b0;
    end

    // R5 forcing without a write
    wr(1'b0, 8'h00);
    @(negedge clk); pll_wait_i = 1'b1;
    @(negedge clk); pll_wait_i = 1'b0;
    rd(1'b0, r); chk("R5 forced auto", r, 8'h20);

    // R6 bandwidth select
    wr(1'b0, 8'h00); chk("R6 manual low", {7'b0, bw_high_o}, 8'h00);
    wr(1'b0, 8'h10); chk("R6 manual high", {7'b0, bw_high_o}, 8'h01);
    wr(1'b0, 8'h20); vco_far_i = 1'b1; #1 chk("R6 auto far", {7'b0, bw_high_o}, 8'h01);
    vco_far_i = 1'b0; #1 chk("R6 auto near", {7'b0, bw_high_o}, 8'h00);

    // R7 PLL enable
    wr(1'b0, 8'h00); chk("R7 pll off", {7'b0, pll_en_o}, 8'h00);
    scm_i = 1'b1; #1 chk("R7 pll in scm", {7'b0, pll_en_o}, 8'h01);
    rd(1'b0, r); chk("R7 latched bit", r, 8'h00);
    scm_i = 1'b0;

    // R13 R8 pseudo stop then full stop
    wr(1'b0, 8'h89);
    pulse_stop(1'b1);
    chk("R13 pseudo stop osc/cm", {6'b0, osc_en_o, cm_en_o}, 8'h03);
    pulse_wake();
    pulse_stop(1'b0);
    chk("R13 R8 full stop osc/cm", {6'b0, osc_en_o, cm_en_o}, 8'h00);

    // R9 fast wake
    pulse_wake();
    chk("R9 fast wake", {4'b0, clk_src_osc_o, osc_en_o, cm_en_o, scm_flag_o}, 8'h00);

    // R10 clearing fast wake starts the check
    wr(1'b0, 8'h81);
    chk("R10 start", {5'b0, qc_start_o, osc_en_o, cm_en_o}, 8'h07);
    @(negedge clk);
    chk("R10 single pulse", {7'b0, qc_start_o}, 8'h00);

    // R11 pass
    qc_report(1'b1);
    chk("R11 pass", {6'b0, clk_src_osc_o, scm_flag_o}, 8'h03);
    wr(1'b1, 8'h01);
    chk("R12 w1c flag", {7'b0, scm_flag_o}, 8'h00);

    // R12 fail path
    wr(1'b0, 8'h89);
    pulse_stop(1'b0);
    pulse_wake();
    wr(1'b0, 8'h81);
    qc_report(1'b0);
    chk("R12 fail", {5'b0, clk_src_osc_o, scm_flag_o, osc_en_o}, 8'h01);

    // R3 monitor lock while the sequencer holds self-clock
    wr(1'b0, 8'h01);
    rd(1'b0, r); chk("R3 seq lock", r, 8'h81);

    // R9 plain wake when self-clock enable is 0
    wr(1'b0, 8'h88);
    pulse_stop(1'b0);
    pulse_wake();
    chk("R9 plain wake", {6'b0, clk_src_osc_o, scm_flag_o}, 8'h02);

    finish_run();
  end
endmodule